// File: doc/BRIEF.md
# Timer interrupt flag and mask unit

This block keeps the pending-event flags and the per-source enable bits for one timer that has three event sources: counter overflow, compare match A and compare match B. The timer core sends each event as a one-cycle pulse, and the pulse latches into a flag. Software reads and writes two byte-wide registers over a simple register bus. One register holds the enable mask and the other holds the flags. Writing a one to a flag bit clears that flag.

The block raises a registered interrupt request towards the CPU. The request is raised when the global interrupt enable input is high and at least one source has both its flag and its mask bit set. Alongside the request, a 2-bit vector ID names the winning source. A fixed priority picks the winner: compare A, then compare B, then overflow. When the CPU takes the vector, it pulses the acknowledge input. The pulse clears only the flag of the source named by the vector ID.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: Mask register (reg_addr = 0) is read/write storage. Bit 0 enables overflow, bit 1 enables compare A and bit 2 enables compare B. A write updates it at the next clock edge.
- R2: The flag register (reg_addr = 1) uses the same bit positions as the mask. A pulse on evt_ovf, evt_cmpa or evt_cmpb sets bit 0, bit 1 or bit 2 respectively at the next clock edge.
- R3: Bits 7 to 3 of both registers always read as zero. Writes to those bits have no effect.
- R4: After reset, both registers read zero, irq_req is low and irq_id is 0.
- R5: Writing a one to a flag bit clears that flag. Writing a zero to a flag bit leaves it unchanged.
- R6: If an event pulse and a clearing write (or an acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R7: When irq_ack is high while irq_req is high, the flag named by irq_id is cleared at that edge. All other flags are unaffected. An acknowledge while irq_req is low changes nothing.
- R8: irq_req is a register. After each edge it is high exactly when gie was high at that edge and some flag has its mask bit set, judged on the register state after that edge.
- R9: A flag sets even while its mask bit is zero. Writing the mask never changes any flag.
- R10: irq_id is encoded as 0 = overflow, 1 = compare A, 2 = compare B. It names the highest-priority enabled pending source, where compare A beats compare B and compare B beats overflow. It reads 0 whenever irq_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_ovf | input | 1 | Overflow event pulse |
| evt_cmpa | input | 1 | Compare match A event pulse |
| evt_cmpb | input | 1 | Compare match B event pulse |
| gie | input | 1 | Global interrupt enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 = mask, 1 = flags |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| irq_req | output | 1 | Registered interrupt request |
| irq_id | output | 2 | Vector ID of the winning source |
| irq_ack | input | 1 | Vector acknowledge pulse |

## Verification
Every flag and mask bit can be read back in the cycle after the edge that changes it, so a wrong bit shows up on reg_rdata one cycle after the cause. A flag that is set wrongly, or lost, also shows on irq_req and irq_id at that same edge, provided the source is enabled and gie is high. A wrong priority choice only shows as a wrong irq_id, and only when two or more enabled flags are pending. For that reason the stimulus builds up overlapping pending sources on purpose. A wrong acknowledge target shows one edge later as the wrong flag missing from the flag register.

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_ovf,
  input  logic          evt_cmpa,
  input  logic          evt_cmpb,
  input  logic          gie,
  input  logic          reg_wr,
  input  logic          reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_req,
  output logic [1:0]    irq_id,
  input  logic          irq_ack
);
  localparam int NSRC = 3;
  localparam logic [1:0] ID_OVF  = 2'd0;
  localparam logic [1:0] ID_CMPA = 2'd1;
  localparam logic [1:0] ID_CMPB = 2'd2;

  logic [NSRC-1:0] mask_q, flag_q, mask_d, flag_d;
  logic [NSRC-1:0] evt, w1c, ack_hit, pend_d;
  logic [1:0]      id_d;
  logic            req_d;

  assign evt = {evt_cmpb, evt_cmpa, evt_ovf};
  assign w1c = (reg_wr && reg_addr) ? reg_wdata[NSRC-1:0] : '0;

  always_comb begin
    for (int i = 0; i < NSRC; i++)
      ack_hit[i] = irq_req && irq_ack && (irq_id == 2'(i));
  end

  assign flag_d = evt | (flag_q & ~w1c & ~ack_hit);
  assign mask_d = (reg_wr && !reg_addr) ? reg_wdata[NSRC-1:0] : mask_q;
  assign pend_d = flag_d & mask_d;
  assign req_d  = gie && (|pend_d);

  always_comb begin
    if (pend_d[ID_CMPA])      id_d = ID_CMPA;
    else if (pend_d[ID_CMPB]) id_d = ID_CMPB;
    else                      id_d = ID_OVF;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      flag_q  <= '0;
      irq_req <= 1'b0;
      irq_id  <= ID_OVF;
    end else begin
      mask_q  <= mask_d;
      flag_q  <= flag_d;
      irq_req <= req_d;
      irq_id  <= req_d ? id_d : ID_OVF;
    end
  end

  assign reg_rdata = {{(DW-NSRC){1'b0}}, (reg_addr ? flag_q : mask_q)};
endmodule

module tmr_irq_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          evt_ovf,
  input logic          evt_cmpa,
  input logic          evt_cmpb,
  input logic          gie,
  input logic          reg_wr,
  input logic          reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] reg_rdata,
  input logic          irq_req,
  input logic [1:0]    irq_id,
  input logic          irq_ack,
  input logic [2:0]    flag_q,
  input logic [2:0]    mask_q
);
  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DW-1:3] == '0);

  assert_evt_sets_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cmpa |=> flag_q[1]);

  assert_evt_sets_ovf_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ovf |=> flag_q[0]);

  assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr && reg_wdata[2] && !evt_cmpb) |=> !flag_q[2]);

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack && irq_id == 2'd1 && !evt_cmpa) |=> !flag_q[1]);

  assert_req_needs_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((flag_q & mask_q) != 3'b000));

  assert_req_needs_gie_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $past(gie));

  assert_mask_write_keeps_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr && !evt_ovf && !evt_cmpa && !evt_cmpb && !(irq_req && irq_ack))
      |=> $stable(flag_q));

  assert_prio_a_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && flag_q[1] && mask_q[1]) |-> irq_id == 2'd1);

  assert_id_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> irq_id == 2'd0);
endmodule

bind tmr_irq_ctrl tmr_irq_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_ovf(evt_ovf), .evt_cmpa(evt_cmpa),
  .evt_cmpb(evt_cmpb), .gie(gie), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
  .irq_id(irq_id), .irq_ack(irq_ack), .flag_q(flag_q), .mask_q(mask_q)
);

// File: tb/tmr_irq_ctrl_bench.sv
module tmr_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt_ovf = 1'b0, evt_cmpa = 1'b0, evt_cmpb = 1'b0;
  logic       gie = 1'b0, reg_wr = 1'b0, reg_addr = 1'b0, irq_ack = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq_req;
  logic [1:0] irq_id;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  tmr_irq_ctrl u_tmr_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_ovf(evt_ovf), .evt_cmpa(evt_cmpa),
    .evt_cmpb(evt_cmpb), .gie(gie), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
    .irq_id(irq_id), .irq_ack(irq_ack)
  );

  typedef struct packed {
    logic [2:0] evt;   // {cmpb, cmpa, ovf}
    logic       wr;
    logic       addr;
    logic [7:0] wdata;
    logic       ack;
    logic       g;
    logic [2:0] ef;
    logic [2:0] em;
    logic       eirq;
    logic [1:0] eid;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{3'b001, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 3'b001, 3'b000, 1'b0, 2'd0, 4'd9 },  // R9 flag sets with mask zero
    '{3'b000, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b1, 3'b001, 3'b111, 1'b1, 2'd0, 4'd1 },  // R1 mask write, R3 upper bits dropped
    '{3'b100, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 3'b101, 3'b111, 1'b1, 2'd2, 4'd10},  // R10 B beats overflow
    '{3'b010, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 3'b111, 3'b111, 1'b1, 2'd1, 4'd10},  // R10 A beats all
    '{3'b000, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 3'b101, 3'b111, 1'b1, 2'd2, 4'd7 },  // R7 ack clears A only
    '{3'b000, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 3'b101, 3'b111, 1'b0, 2'd0, 4'd8 },  // R8 gie low blocks
    '{3'b000, 1'b1, 1'b1, 8'h04, 1'b0, 1'b1, 3'b001, 3'b111, 1'b1, 2'd0, 4'd5 },  // R5 write one clears B
    '{3'b000, 1'b1, 1'b1, 8'h00, 1'b0, 1'b1, 3'b001, 3'b111, 1'b1, 2'd0, 4'd5 },  // R5 write zero keeps
    '{3'b010, 1'b1, 1'b1, 8'h02, 1'b0, 1'b1, 3'b011, 3'b111, 1'b1, 2'd1, 4'd6 },  // R6 set wins over clear
    '{3'b000, 1'b1, 1'b0, 8'h01, 1'b0, 1'b1, 3'b011, 3'b001, 1'b1, 2'd0, 4'd9 },  // R9 mask write keeps flags
    '{3'b000, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 3'b010, 3'b001, 1'b0, 2'd0, 4'd7 },  // R7 ack of overflow
    '{3'b000, 1'b1, 1'b1, 8'hFF, 1'b0, 1'b1, 3'b000, 3'b001, 1'b0, 2'd0, 4'd5 },  // R5 clear all
    '{3'b000, 1'b1, 1'b0, 8'hF8, 1'b0, 1'b1, 3'b000, 3'b000, 1'b0, 2'd0, 4'd3 },  // R3 reserved-only write
    '{3'b001, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 3'b001, 3'b000, 1'b0, 2'd0, 4'd7 }   // R7 ack ignored while idle
  };

  task automatic chk(input string what, input int req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic read_regs(input int req, input logic [2:0] ef, input logic [2:0] em);
    reg_addr = 1'b1; #0.5;
    chk("flags", req, reg_rdata, {5'b0, ef});
    reg_addr = 1'b0; #0.5;
    chk("mask", req, reg_rdata, {5'b0, em});
  endtask

  initial begin
    #50000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R4 reset state
    chk("irq after reset R4", 4, {7'b0, irq_req}, 8'h00);
    chk("id after reset R4", 4, {6'b0, irq_id}, 8'h00);
    read_regs(4, 3'b000, 3'b000);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {evt_cmpb, evt_cmpa, evt_ovf} = VEC[i].evt;
      reg_wr = VEC[i].wr; reg_addr = VEC[i].addr; reg_wdata = VEC[i].wdata;
      irq_ack = VEC[i].ack; gie = VEC[i].g;
      @(posedge clk); #1;
      {evt_cmpb, evt_cmpa, evt_ovf} = 3'b000;
      reg_wr = 1'b0; irq_ack = 1'b0;
      chk($sformatf("irq vec%0d", i), int'(VEC[i].req), {7'b0, irq_req}, {7'b0, VEC[i].eirq});
      chk($sformatf("id vec%0d", i), int'(VEC[i].req), {6'b0, irq_id}, {6'b0, VEC[i].eid});
      read_regs(int'(VEC[i].req), VEC[i].ef, VEC[i].em);
    end

    // R2 compare B event sets bit 2; R8 irq follows once enabled
    @(negedge clk);
    evt_cmpb = 1'b1;
    @(posedge clk); #1; evt_cmpb = 1'b0;
    read_regs(2, 3'b101, 3'b000);
    chk("irq masked R8", 8, {7'b0, irq_req}, 8'h00);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 8'h04;
    @(posedge clk); #1; reg_wr = 1'b0;
    chk("irq after enable R8", 8, {7'b0, irq_req}, 8'h01);
    chk("id B R10", 10, {6'b0, irq_id}, 8'h02);

    // R6 event and ack on the same flag: flag stays set
    @(negedge clk);
    evt_cmpb = 1'b1; irq_ack = 1'b1;
    @(posedge clk); #1; evt_cmpb = 1'b0; irq_ack = 1'b0;
    read_regs(6, 3'b101, 3'b100);
    chk("irq kept R6", 6, {7'b0, irq_req}, 8'h01);

    // R4 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    read_regs(4, 3'b000, 3'b000);
    chk("irq reset R4", 4, {7'b0, irq_req}, 8'h00);
    rst_n = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule